// File: doc/BRIEF.md
# Pulse-Per-Second Time-Lag Phase Detector

This block disciplines a voltage-controlled crystal oscillator to a once-per-second timing pulse. The oscillator itself clocks all of the logic. A divider reduces the oscillator to a lower-rate tick, and the divide ratio comes from a small computed table that a select input indexes. On each rising edge of the pulse-per-second input, a counter starts. It advances once every four oscillator cycles and stops at the next tick of the divider. The resulting lag is captured at the following second pulse and held for the whole second. A first-order pulse-width modulator turns the held lag into a single output bit, which feeds an external analog loop filter that tunes the oscillator.

The lag stays the same from one second to the next only when the oscillator runs at a whole multiple of the divide ratio in hertz. If the oscillator runs fast, the lag shrinks. If it runs slow, the lag grows. The analog loop therefore settles at the nearest such multiple. Each divide ratio is about four times the lag counter's full scale, so the whole output range is usable.

The measurement is controlled by a three-state machine. The states are ST_IDLE, ST_MEASURE and ST_DONE. The machine moves from ST_IDLE to ST_MEASURE on the first second pulse after reset, without capturing anything. It moves from ST_MEASURE to ST_DONE on a divider tick. On a second pulse it moves from ST_DONE to ST_MEASURE, and a second pulse in ST_MEASURE keeps it in ST_MEASURE. Both of those pulse transitions capture the lag and restart it. If a second pulse and a divider tick arrive in the same cycle, the second pulse wins.

Top module: `pps_lag_detector`

## Requirements
- R1: The divide ratio is DIV_BASE + DIV_STEP*ratio_sel. With the defaults (1024, 8), select values 0, 1, 2 and 3 give ratios of 1024, 1032, 1040 and 1048 oscillator cycles.
- R2: The second-pulse input passes through a two-flop synchronizer, and only its rising edge acts. A pulse held high for hundreds of cycles counts as one event.
- R3: The lag counter clears on a second-pulse edge. It advances once per four oscillator cycles until the next divider tick. Moving a second pulse later by 4*m oscillator cycles, relative to the divider, lowers the lag by exactly m.
- R4: When the interval between second pulses is a whole multiple of the divide ratio, consecutive captured lags are equal. An interval that is 4*d cycles longer lowers each capture by d, and one that is 4*d cycles shorter raises it by d.
- R5: The captured lag changes only at a second-pulse edge and holds its value between edges.
- R6: The lag counter stops at 2^LAG_W-1 (255 by default) rather than wrapping to zero.
- R7: Over any 2^LAG_W consecutive cycles, pwm_out is high for exactly as many cycles as the captured lag. A captured lag of 0 keeps pwm_out low.
- R8: After reset, the captured lag is mid-scale, 2^(LAG_W-1) (128 by default). The first second pulse after reset leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | Oscillator clock; drives all logic |
| rst | input | 1 | Synchronous active-high reset |
| pps_async | input | 1 | Asynchronous once-per-second timing pulse |
| ratio_sel | input | SEL_W | Selects the divide ratio from the table |
| pwm_out | output | 1 | Pulse-width modulated lag for the loop filter |

## Verification
Two corner cases are the hardest to reach from the ports: a lag at full-scale saturation and a lag of exactly one count. Both depend on where the second pulse falls relative to a divider tick that cannot be seen from outside. The stimulus reads the held lag as the high-cycle count of pwm_out over one full modulator period. It then makes one pulse interval longer by four times the difference between that reading and the target lag, which places the lag exactly. From a known lag, a run of intervals slightly shorter than the ratio walks the lag up into saturation and on past the wrap of the divider phase.

// File: rtl/pps_lock_pkg.sv
package pps_lock_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_MEASURE = 2'd1,
        ST_DONE    = 2'd2
    } lag_state_e;

endpackage

// File: rtl/pps_edge_sync.sv
module pps_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pps_async,
    output logic pps_rise
);
    // chain[STAGES-1] is the synchronized level, chain[STAGES] its delayed copy
    logic [STAGES:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-1:0], pps_async};
        end
    end

    assign pps_rise = chain_q[STAGES-1] & ~chain_q[STAGES];

endmodule

// File: rtl/osc_ratio_divider.sv
module osc_ratio_divider #(
    parameter int SEL_W    = 2,
    parameter int DIV_BASE = 1024,
    parameter int DIV_STEP = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SEL_W-1:0] ratio_sel,
    output logic             div_tick
);
    localparam int NSEL  = 1 << SEL_W;
    localparam int MAXR  = DIV_BASE + DIV_STEP * (NSEL - 1);
    localparam int CNT_W = $clog2(MAXR + 1);

    logic [CNT_W-1:0] ratio_tbl [NSEL];
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] top_val;

    for (genvar g = 0; g < NSEL; g++) begin : g_ratio
        assign ratio_tbl[g] = CNT_W'(DIV_BASE + DIV_STEP * g);
    end

    assign top_val  = ratio_tbl[ratio_sel] - 1'b1;
    // >= so a switch to a shorter ratio never overshoots the wrap point
    assign div_tick = (cnt_q >= top_val);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (div_tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/lag_meter.sv
module lag_meter
    import pps_lock_pkg::*;
#(
    parameter int LAG_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pps_rise,
    input  logic             div_tick,
    output logic [LAG_W-1:0] level,
    output logic [LAG_W-1:0] lag_count,
    output logic [1:0]       phase4,
    output lag_state_e       state
);
    localparam logic [LAG_W-1:0] LAG_MAX = '1;
    localparam logic [LAG_W-1:0] LAG_MID = {1'b1, {(LAG_W-1){1'b0}}};

    lag_state_e       state_q, state_d;
    logic [1:0]       seq_q;
    logic [LAG_W-1:0] lag_q;
    logic [LAG_W-1:0] level_q;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state: a second pulse outranks a divider tick
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (pps_rise) state_d = ST_MEASURE;
            ST_MEASURE: if (pps_rise) state_d = ST_MEASURE;
                        else if (div_tick) state_d = ST_DONE;
            ST_DONE:    if (pps_rise) state_d = ST_MEASURE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // outputs: quarter-rate sequencer, saturating lag, held level
    always_ff @(posedge clk) begin
        if (rst) begin
            seq_q   <= '0;
            lag_q   <= '0;
            level_q <= LAG_MID;
        end else begin
            seq_q <= seq_q + 2'd1;
            if (pps_rise) begin
                lag_q <= '0;
            end else if (state_q == ST_MEASURE && seq_q == 2'd3 && lag_q != LAG_MAX) begin
                lag_q <= lag_q + 1'b1;
            end
            if (pps_rise && state_q != ST_IDLE) begin
                level_q <= lag_q;
            end
        end
    end

    assign level     = level_q;
    assign lag_count = lag_q;
    assign phase4    = seq_q;
    assign state     = state_q;

endmodule

// File: rtl/pwm_dac.sv
module pwm_dac #(
    parameter int LAG_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LAG_W-1:0] level,
    output logic             pwm_bit
);
    logic [LAG_W-1:0] ramp_q;
    logic             pwm_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ramp_q <= '0;
            pwm_q  <= 1'b0;
        end else begin
            ramp_q <= ramp_q + 1'b1;
            pwm_q  <= (ramp_q < level);
        end
    end

    assign pwm_bit = pwm_q;

endmodule

// File: rtl/pps_lag_detector.sv
module pps_lag_detector
    import pps_lock_pkg::*;
#(
    parameter int LAG_W       = 8,
    parameter int SEL_W       = 2,
    parameter int DIV_BASE    = 1024,
    parameter int DIV_STEP    = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk_osc,
    input  logic             rst,
    input  logic             pps_async,
    input  logic [SEL_W-1:0] ratio_sel,
    output logic             pwm_out
);
    logic             pps_rise;
    logic             div_tick;
    logic [LAG_W-1:0] level;
    logic [LAG_W-1:0] lag_count;
    logic [1:0]       phase4;
    lag_state_e       state;

    pps_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk_osc), .rst(rst), .pps_async(pps_async), .pps_rise(pps_rise)
    );

    osc_ratio_divider #(.SEL_W(SEL_W), .DIV_BASE(DIV_BASE), .DIV_STEP(DIV_STEP)) u_div (
        .clk(clk_osc), .rst(rst), .ratio_sel(ratio_sel), .div_tick(div_tick)
    );

    lag_meter #(.LAG_W(LAG_W)) u_meter (
        .clk(clk_osc), .rst(rst), .pps_rise(pps_rise), .div_tick(div_tick),
        .level(level), .lag_count(lag_count), .phase4(phase4), .state(state)
    );

    pwm_dac #(.LAG_W(LAG_W)) u_pwm (
        .clk(clk_osc), .rst(rst), .level(level), .pwm_bit(pwm_out)
    );

endmodule

// File: rtl/pps_lag_checker.sv
module pps_lag_checker
    import pps_lock_pkg::*;
#(
    parameter int LAG_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             pps_rise,
    input logic [LAG_W-1:0] level,
    input logic [LAG_W-1:0] lag_count,
    input logic [1:0]       phase4,
    input lag_state_e       state,
    input logic             pwm_out
);
    localparam logic [LAG_W-1:0] LAG_MAX = '1;
    localparam logic [LAG_W-1:0] LAG_MID = {1'b1, {(LAG_W-1){1'b0}}};

    AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        pps_rise |=> !pps_rise); // R2

    AST_QUARTER_RATE: assert property (@(posedge clk) disable iff (rst)
        (!$past(pps_rise) && lag_count != $past(lag_count)) |-> $past(phase4) == 2'd3); // R3

    AST_LEVEL_HELD: assert property (@(posedge clk) disable iff (rst)
        !pps_rise |=> $stable(level)); // R5

    AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
        (lag_count == LAG_MAX && !pps_rise) |=> lag_count == LAG_MAX); // R6

    AST_PWM_ZERO: assert property (@(posedge clk) disable iff (rst)
        (level == '0) |=> !pwm_out); // R7

    AST_IDLE_MID: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |-> level == LAG_MID); // R8

endmodule

bind pps_lag_detector pps_lag_checker #(.LAG_W(LAG_W)) u_chk (
    .clk(clk_osc), .rst(rst), .pps_rise(pps_rise), .level(level),
    .lag_count(lag_count), .phase4(phase4), .state(state), .pwm_out(pwm_out)
);

// File: tb/pps_lag_detector_test.sv
module pps_lag_detector_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pps_async = 1'b0;
    logic [1:0] ratio_sel = 2'd0;
    logic       pwm_out;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    // vector table: select, pulse interval, expected lag change per second
    localparam int NV = 9;
    localparam int VSEL [NV] = '{0, 0, 0, 0, 1, 1, 2, 3, 3};
    localparam int VPER [NV] = '{1024, 2048, 1028, 1016, 1032, 1040, 1040, 1048, 1040};
    localparam int VDLT [NV] = '{0, 0, -1, 2, 0, -2, 0, 0, 2};

    always #5 clk = ~clk;

    pps_lag_detector uut (
        .clk_osc(clk), .rst(rst), .pps_async(pps_async),
        .ratio_sel(ratio_sel), .pwm_out(pwm_out)
    );

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int ratio_of(input int sel);
        return 1024 + 8 * sel; // R1 table
    endfunction

    // one pulse of width W, then T cycles in total; hi = PWM high count over 256 cycles
    task automatic call_pps(input int T, input int W, output int hi);
        int hi2;
        hi  = 0;
        hi2 = 0;
        for (int c = 0; c < T; c++) begin
            pps_async = (c < W);
            if (c >= 20 && c < 276) hi += int'(pwm_out);
            if (c >= 600 && c < 856) hi2 += int'(pwm_out);
            @(negedge clk);
        end
        if (T >= 900) check("R5 held lag unchanged within second", hi2, hi);
    endtask

    // leaves the lag of the last pulse equal to tgt under ratio rr
    task automatic recenter(input int rr, input int tgt);
        int r;
        call_pps(rr, 10, r);
        call_pps(rr, 10, r);
        call_pps(rr, 10, r);
        if (r == 255) begin
            call_pps(rr + 400, 10, r);
            call_pps(rr, 10, r);
            call_pps(rr, 10, r);
        end
        call_pps(rr + 4 * (r - tgt), 10, r);
        call_pps(rr, 10, r);
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R1 watchdog: actual=timeout expected=completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int hi, rr, prev, n255, drops;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);

        // R8: mid-scale after reset, first pulse ignored
        hi = 0;
        for (int c = 0; c < 256; c++) begin
            hi += int'(pwm_out);
            @(negedge clk);
        end
        check("R8 mid-scale after reset", hi, 128);
        call_pps(1024, 10, hi);
        check("R8 first pulse leaves mid-scale", hi, 128);

        // R1/R3/R4 vector walk
        for (int v = 0; v < NV; v++) begin
            ratio_sel = 2'(VSEL[v]);
            rr = ratio_of(VSEL[v]);
            recenter(rr, 128);
            call_pps(VPER[v], 10, hi);
            check("R3 lag placed by 4-cycle shift", hi, 128);
            call_pps(VPER[v], 10, hi);
            check("R4 lag before drift", hi, 128);
            call_pps(VPER[v], 10, hi);
            check("R1 R4 lag after one interval", hi, 128 + VDLT[v]);
            call_pps(VPER[v], 10, hi);
            check("R4 lag after two intervals", hi, 128 + 2 * VDLT[v]);
        end

        // R2: a long-held pulse is one event
        ratio_sel = 2'd0;
        recenter(1024, 100);
        call_pps(1024, 600, hi);
        check("R2 long pulse capture", hi, 100);
        call_pps(1024, 10, hi);
        check("R2 long pulse acts once", hi, 100);

        // R7: duty of a one-count lag
        recenter(1024, 1);
        call_pps(1024, 10, hi);
        check("R7 duty for lag 1", hi, 1);

        // R6: walk the lag up into saturation and past the divider wrap
        ratio_sel = 2'd3;
        recenter(1048, 200);
        prev  = 200;
        n255  = 0;
        drops = 0;
        for (int k = 0; k < 24; k++) begin
            call_pps(1032, 10, hi);
            if (hi == 255) n255++;
            if (hi < prev) begin
                drops++;
                check("R6 drop only after saturation", prev, 255);
            end
            prev = hi;
        end
        check("R6 saturated reads", (n255 >= 2) ? 1 : 0, 1);
        check("R6 divider wrap seen", (drops >= 1) ? 1 : 0, 1);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule